// File: doc/BRIEF.md
# Memory Fence Stall Controller

This block sits next to a processor core's load/store machinery and keeps a running count of the memory transactions that the core has started and that have not yet finished. Traffic is split into six classes, each with its own counter. When software issues a fence, the block holds the core stalled until every one of these counters has drained to zero. Software uses this to wait until its requests have reached their destination. It also uses it to order writes that reach one endpoint by different paths.

Each class drives a one-cycle issue pulse when a transaction of that class starts and a one-cycle retire pulse when it finishes. A fence request is a single-cycle pulse. The stall output and the done pulse are combinational functions of the registered counts and the fence state, so the core sees the stall in the same cycle it asks for the fence. A retire pulse with no matching outstanding transaction is caught and reported on a sticky error flag.

Top module: `mfence_stall_ctrl`

## Requirements
- R1: After reset, `stall`, `fence_done` and `underflow_err` are all low and every counter reads zero.
- R2: A fence requested while no class has outstanding transactions raises `fence_done` in that same cycle, and `stall` stays low.
- R3: A fence requested while any counter is nonzero raises `stall` in that same cycle, and `stall` stays high in every following cycle until all counters read zero.
- R4: `fence_done` goes high, with `stall` low, in the first cycle of a pending fence in which every counter reads zero. It is one cycle wide unless a new fence is requested.
- R5: An issue pulse and a retire pulse on the same class in the same cycle leave that counter unchanged.
- R6: Transactions issued while a fence is pending are counted and must also retire before the fence completes.
- R7: Bit positions of `issue` and `retire` select the class: bit 0 line fills, bit 1 writes toward the next level or system endpoints, bit 2 victim write-backs, bit 3 block or global coherence operations, bit 4 cache mode changes, bit 5 prefetch requests. An outstanding transaction in any single class holds a fence.
- R8: A retire pulse on a class whose counter is zero, without an issue on that class in the same cycle, sets `underflow_err` from the next cycle on until reset. The counter stays at zero.
- R9: A fence request while a fence is already pending has no effect: the pending fence completes with a single done pulse.
- R10: An issue and a retire on the same class in the same cycle while that counter is zero do not set `underflow_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | NUM_CLASSES | Per-class transaction start pulse |
| retire | input | NUM_CLASSES | Per-class transaction completion pulse |
| fence_req | input | 1 | Fence request pulse |
| stall | output | 1 | Core stall, high while a fence waits for traffic to drain |
| fence_done | output | 1 | One-cycle pulse when a fence completes |
| underflow_err | output | 1 | Sticky flag for a retire with nothing outstanding |

## Verification
The hardest case to reach from the ports is a fence that stays held by traffic that started after the fence was accepted, while the traffic that was outstanding at acceptance has already retired. The stimulus reaches it by issuing on one class, fencing, issuing on a second class during the stall, and then retiring the first class alone. The stall must survive that retire. A related case is a counter that took an underflow retire. Here a later single issue and fence must still stall for exactly one retire, which shows the counter never went below zero.

// File: rtl/mfence_pkg.sv
// Package: shared types for the memory fence stall controller.
// Assumes: one fence can be pending at a time.
package mfence_pkg;

    // Fence sequencing state: idle or waiting for counters to drain
    typedef enum logic [0:0] {
        FENCE_IDLE = 1'b0,
        FENCE_WAIT = 1'b1
    } fence_state_e;

endpackage

// File: rtl/mfence_class_counter.sv
// Module: outstanding-transaction counter for one traffic class.
// Counts up on issue and down on retire. Both together leave the count alone.
// A retire with the count at zero and no issue is flagged and ignored.
// Assumes: the number outstanding never exceeds 2**CNT_W-1.
module mfence_class_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic underflow
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // Next-count selection and underflow detection
    always_comb begin
        count_d   = count_q;
        underflow = 1'b0;
        if (inc && !dec) begin
            count_d = count_q + ONE;
        end else if (dec && !inc) begin
            if (count_q == '0) begin
                underflow = 1'b1;
            end else begin
                count_d = count_q - ONE;
            end
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign is_zero = (count_q == '0);

endmodule

// File: rtl/mfence_sticky_flag.sv
// Module: sticky error flag. Set by any bit of a pulse vector and cleared
// only by reset.
// Assumes: the flag is read by software outside this block.
module mfence_sticky_flag #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    output logic         flag
);

    logic flag_q;

    // Hold the flag once any set bit arrives
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (|set_vec)   flag_q <= 1'b1;
    end

    assign flag = flag_q;

endmodule

// File: rtl/mfence_seq.sv
// Module: fence sequencer. It accepts a fence request, holds it pending
// until the drain signal reports all classes empty, and drives stall and done.
// Assumes: all_zero reflects registered counts, so the outputs have no
// combinational path from the issue or retire inputs.
module mfence_seq
    import mfence_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic all_zero,
    output logic stall,
    output logic fence_done
);

    fence_state_e state_q;
    fence_state_e state_d;
    logic         pending;

    // A fence is live if one is waiting or one arrives now
    always_comb begin
        pending    = (state_q == FENCE_WAIT) || fence_req;
        stall      = pending && !all_zero;
        fence_done = pending && all_zero;
        state_d    = (pending && !all_zero) ? FENCE_WAIT : FENCE_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FENCE_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/mfence_stall_ctrl.sv
// Module: memory fence stall controller (top). It keeps one outstanding-
// transaction counter per traffic class, combines the zero flags and stalls
// a fence until all classes have drained.
// Assumes: issue and retire are single-cycle pulses per transaction.
module mfence_stall_ctrl #(
    parameter int NUM_CLASSES = 6,
    parameter int CNT_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLASSES-1:0] issue,
    input  logic [NUM_CLASSES-1:0] retire,
    input  logic                   fence_req,
    output logic                   stall,
    output logic                   fence_done,
    output logic                   underflow_err
);

    logic [NUM_CLASSES-1:0] zero_vec;
    logic [NUM_CLASSES-1:0] uflow_vec;
    logic                   all_zero;

    // One counter per class
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
        mfence_class_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (issue[g]),
            .dec       (retire[g]),
            .is_zero   (zero_vec[g]),
            .underflow (uflow_vec[g])
        );
    end

    assign all_zero = &zero_vec;

    mfence_sticky_flag #(.N(NUM_CLASSES)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (uflow_vec),
        .flag    (underflow_err)
    );

    mfence_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fence_req  (fence_req),
        .all_zero   (all_zero),
        .stall      (stall),
        .fence_done (fence_done)
    );

endmodule

// File: rtl/mfence_stall_ctrl_chk.sv
// Module: property checker for the fence controller, bound to the top.
module mfence_stall_ctrl_chk #(
    parameter int NUM_CLASSES = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CLASSES-1:0] issue,
    input logic [NUM_CLASSES-1:0] retire,
    input logic                   fence_req,
    input logic                   stall,
    input logic                   fence_done,
    input logic                   underflow_err
);

    // R4: done and stall never together
    assert_done_not_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !stall);

    // R3: stall only drops through a done pulse
    assert_stall_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (stall || fence_done));

    // R2: an unstalled fence request completes at once
    assert_idle_fence_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && !stall) |-> fence_done);

    // R6: a net new issue during a stall keeps the stall
    assert_issue_holds_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && |(issue & ~retire)) |=> stall);

    // R8: the underflow flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

endmodule

bind mfence_stall_ctrl mfence_stall_ctrl_chk #(.NUM_CLASSES(NUM_CLASSES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .retire        (retire),
    .fence_req     (fence_req),
    .stall         (stall),
    .fence_done    (fence_done),
    .underflow_err (underflow_err)
);

// File: tb/mfence_stall_ctrl_test.sv
module mfence_stall_ctrl_test;

    localparam int NC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] issue = '0;
    logic [NC-1:0] retire = '0;
    logic          fence_req = 1'b0;
    logic          stall;
    logic          fence_done;
    logic          underflow_err;

    int n_checks = 0;
    int n_fails  = 0;

    logic o_stall, o_done, o_err;

    always #10 clk = ~clk;

    mfence_stall_ctrl #(.NUM_CLASSES(NC), .CNT_W(4)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue         (issue),
        .retire        (retire),
        .fence_req     (fence_req),
        .stall         (stall),
        .fence_done    (fence_done),
        .underflow_err (underflow_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Apply one cycle of inputs, capture outputs mid-cycle, then clear inputs
    task automatic step(input logic [NC-1:0] iss, input logic [NC-1:0] ret, input logic fr);
        issue = iss; retire = ret; fence_req = fr;
        @(negedge clk);
        o_stall = stall; o_done = fence_done; o_err = underflow_err;
        @(posedge clk); #1;
        issue = '0; retire = '0; fence_req = 1'b0;
    endtask

    task automatic t_reset();
        step('0, '0, 1'b0);
        chk("R1", "stall", o_stall, 1'b0);
        chk("R1", "done", o_done, 1'b0);
        chk("R1", "err", o_err, 1'b0);
        step('0, '0, 1'b1);
        chk("R1", "counters zero, fence done", o_done, 1'b1);
    endtask

    task automatic t_idle_fence();
        step('0, '0, 1'b1);
        chk("R2", "done", o_done, 1'b1);
        chk("R2", "stall", o_stall, 1'b0);
    endtask

    task automatic t_single_class(input int k);
        logic [NC-1:0] b = NC'(1) << k;
        step(b, '0, 1'b0);
        step('0, '0, 1'b1);
        chk("R3", $sformatf("stall at accept class %0d", k), o_stall, 1'b1);
        chk("R3", "no done at accept", o_done, 1'b0);
        step('0, '0, 1'b0);
        chk("R7", $sformatf("class %0d holds", k), o_stall, 1'b1);
        step('0, b, 1'b0);
        chk("R4", "still stalled in retire cycle", o_stall, 1'b1);
        chk("R4", "no done in retire cycle", o_done, 1'b0);
        step('0, '0, 1'b0);
        chk("R4", "done when drained", o_done, 1'b1);
        chk("R4", "stall low when done", o_stall, 1'b0);
        step('0, '0, 1'b0);
        chk("R4", "done one cycle", o_done, 1'b0);
    endtask

    task automatic t_multi();
        for (int i = 0; i < 3; i++) step(6'b000001, '0, 1'b0);
        step('0, '0, 1'b1);
        chk("R3", "stall with count 3", o_stall, 1'b1);
        step('0, 6'b000001, 1'b0);
        step('0, 6'b000001, 1'b0);
        step('0, '0, 1'b0);
        chk("R3", "stall with count 1", o_stall, 1'b1);
        step('0, 6'b000001, 1'b0);
        step('0, '0, 1'b0);
        chk("R4", "done after three retires", o_done, 1'b1);
    endtask

    task automatic t_issue_pending();
        step(6'b000010, '0, 1'b0);
        step('0, '0, 1'b1);
        step(6'b000100, '0, 1'b0);
        step('0, 6'b000010, 1'b0);
        step('0, '0, 1'b0);
        chk("R6", "late issue holds stall", o_stall, 1'b1);
        chk("R6", "no done yet", o_done, 1'b0);
        step('0, 6'b000100, 1'b0);
        step('0, '0, 1'b0);
        chk("R6", "done after late retire", o_done, 1'b1);
    endtask

    task automatic t_simul();
        step(6'b001000, '0, 1'b0);
        step('0, '0, 1'b1);
        step(6'b001000, 6'b001000, 1'b0);
        step('0, '0, 1'b0);
        chk("R5", "count unchanged, stall", o_stall, 1'b1);
        step('0, 6'b001000, 1'b0);
        step('0, '0, 1'b0);
        chk("R5", "done after one retire", o_done, 1'b1);
    endtask

    task automatic t_refence();
        step(6'b000001, '0, 1'b0);
        step('0, '0, 1'b1);
        step('0, '0, 1'b1);
        chk("R9", "second request still stalled", o_stall, 1'b1);
        chk("R9", "second request no done", o_done, 1'b0);
        step('0, 6'b000001, 1'b0);
        step('0, '0, 1'b0);
        chk("R9", "done", o_done, 1'b1);
        step('0, '0, 1'b0);
        chk("R9", "single done", o_done, 1'b0);
        chk("R9", "no stall after", o_stall, 1'b0);
    endtask

    task automatic t_simul_zero();
        step(6'b010000, 6'b010000, 1'b0);
        step('0, '0, 1'b0);
        chk("R10", "no underflow", o_err, 1'b0);
        step('0, '0, 1'b1);
        chk("R10", "count still zero", o_done, 1'b1);
    endtask

    task automatic t_underflow();
        step('0, 6'b100000, 1'b0);
        chk("R8", "err not yet", o_err, 1'b0);
        step('0, '0, 1'b0);
        chk("R8", "err set", o_err, 1'b1);
        step(6'b100000, '0, 1'b0);
        step('0, '0, 1'b1);
        chk("R8", "counter stayed zero, one issue stalls", o_stall, 1'b1);
        step('0, 6'b100000, 1'b0);
        step('0, '0, 1'b0);
        chk("R8", "done after one retire", o_done, 1'b1);
        chk("R8", "err sticky", o_err, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_idle_fence();
        for (int k = 0; k < NC; k++) t_single_class(k);
        t_multi();
        t_issue_pending();
        t_simul();
        t_refence();
        t_simul_zero();
        t_underflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule